// File: doc/BRIEF.md
# Four-Lane Receive Deskew with Bonding Alignment

This block realigns four byte-wide receive lanes that together carry one 32-bit word per transfer, one byte per lane. Unequal lane delays can leave the bytes in one cycle belonging to different transmitted words. Each lane writes its bytes into its own 16-entry circular buffer and notes where the most recent bonding character landed. The bonding character is the control code 0x7C with its K flag set.

One lane is designated master (lane 0 by default). When the master writes a bonding character, it requests alignment. On the next clock every lane reloads its read pointer to its own recorded bonding position, less a fixed start offset. From then on, all lanes read together, one entry per cycle, and deliver an aligned word. Clock-correction requests (skip one entry, or stall one cycle) come from the master side. They are applied to every lane at once, so the lanes never drift apart. Lowering the bonding enable drops the bond. A fresh bonding character is then needed before words flow again.

The system should make the master the lane with the most delay. Its bonding character then arrives last, and every other lane already holds one.

Top module: `lane_bond_deskew`

## Requirements
- R1: After reset, `bonded` and `word_valid` are both 0.
- R2: A byte is a bonding character only when its K flag is 1 and its value is 0x7C. The value 0x7C with K=0 is plain data and is neither recorded nor able to satisfy the alignment check.
- R3: An align request is raised at the clock edge where the master lane writes a bonding character while `bond_en` is 1 and the block is not bonded. The request is taken on the following edge, where `bonded` rises. A bonding character written while `bond_en` is 0 raises no request.
- R4: The request is taken only if every lane has written a bonding character, and at most 7 further bytes since it, as of the edge where the request is evaluated. Otherwise the request is dropped and `bonded` stays 0. A lane 7 bytes ahead of the master is accepted; a lane 8 bytes ahead is refused.
- R5: Each lane aligns to the position of its latest bonding character written before the align. Once bonded, new bonding characters are neither recorded nor cause realignment, and the word stream continues without a gap.
- R6: Once bonded, `word_out` carries lane k in bits 8k+7:8k. The first word is the transmitted word that lies `BOND_OFFSET` words before the bonding word, and later words follow in transmitted order.
- R7: `word_valid` is 0 on the edge where the align is taken. It is 1 from the next edge whenever a word is read, and it is never 1 while `bonded` is 0.
- R8: With `cc_skip` high while bonded, every lane discards one buffer entry in the same cycle and `word_valid` is 0 for that cycle.
- R9: With `cc_hold` high while bonded, every lane keeps its read pointer and `word_valid` is 0 for that cycle. When both `cc_skip` and `cc_hold` are high, `cc_skip` wins.
- R10: When `bond_en` is 0, `bonded` and `word_valid` go to 0 at the next edge. Words resume only after a new align.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common write and read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_byte | input | 32 | Received bytes, lane k in bits 8k+7:8k |
| lane_k | input | 4 | Control-character flag per lane |
| lane_we | input | 4 | Per-lane write enable |
| bond_en | input | 1 | Permits bonding; 0 drops the bond |
| cc_skip | input | 1 | Master clock-correction skip for all lanes |
| cc_hold | input | 1 | Master clock-correction stall for all lanes |
| word_out | output | 32 | Aligned word |
| word_valid | output | 1 | `word_out` was read this cycle |
| bonded | output | 1 | Lanes are aligned |

## Verification
The bench drives skewed lanes and goes after four alignment decisions:
- **Window boundary.** It tests a skew of exactly 7 bytes and exactly 8 bytes. A window check that is off by one would bond on stale positions or refuse a legal skew.
- **Bonding-character match.** It sends a 0x7C data byte without the K flag, then a later real bonding character. A design that matches on the value alone would bond too early. A design that keeps the first recorded position would deliver mixed words through the offset instance.
- **Clock correction.** It drives skips, stalls and both together. A design that applies them to one lane only, or gives the stall priority, would shift later words by one position.
- **Enable handling.** It drops and restores `bond_en`, and sends bonding characters while already bonded. A design that realigned on these would blank `word_valid` or restart the stream.

// File: rtl/lane_bond_deskew.sv
module lane_bond_deskew #(
  parameter int LANES       = 4,
  parameter int DEPTH       = 16,
  parameter int WIN         = 8,
  parameter int BOND_OFFSET = 0,
  parameter int MASTER      = 0,
  parameter logic [7:0] BOND_CHAR = 8'h7C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LANES*8-1:0]   lane_byte,
  input  logic [LANES-1:0]     lane_k,
  input  logic [LANES-1:0]     lane_we,
  input  logic                 bond_en,
  input  logic                 cc_skip,
  input  logic                 cc_hold,
  output logic [LANES*8-1:0]   word_out,
  output logic                 word_valid,
  output logic                 bonded
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [AW-1:0] OFS = AW'(BOND_OFFSET);

  logic [7:0]    mem  [LANES][DEPTH];
  logic [AW-1:0] wp   [LANES];
  logic [AW-1:0] bpos [LANES];
  logic [AW-1:0] rd   [LANES];
  logic [CW-1:0] age  [LANES];
  logic [LANES-1:0] hit;
  logic all_recent, align_req, take, rd_go;

  always_comb begin
    all_recent = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      hit[i] = lane_we[i] & lane_k[i] & (lane_byte[i*8 +: 8] == BOND_CHAR);
      all_recent &= (age[i] < CW'(WIN));
    end
  end

  assign take  = align_req & bond_en & ~bonded & all_recent;
  assign rd_go = bonded & bond_en & ~cc_skip & ~cc_hold;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (lane_we[i]) mem[i][wp[i]] <= lane_byte[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_req  <= 1'b0;
      bonded     <= 1'b0;
      word_valid <= 1'b0;
      word_out   <= '0;
      for (int i = 0; i < LANES; i++) begin
        wp[i]   <= '0;
        bpos[i] <= '0;
        rd[i]   <= '0;
        age[i]  <= CW'(WIN);
      end
    end else begin
      align_req <= bond_en & ~bonded & hit[MASTER];
      if (!bond_en) begin
        bonded     <= 1'b0;
        word_valid <= 1'b0;
      end else if (take) begin
        bonded     <= 1'b1;
        word_valid <= 1'b0;
        for (int i = 0; i < LANES; i++) rd[i] <= bpos[i] - OFS;
      end else if (bonded) begin
        word_valid <= rd_go;
        for (int i = 0; i < LANES; i++) begin
          if (rd_go) word_out[i*8 +: 8] <= mem[i][rd[i]];
          if (rd_go || cc_skip) rd[i] <= rd[i] + AW'(1);
        end
      end else begin
        word_valid <= 1'b0;
      end
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) wp[i] <= wp[i] + AW'(1);
        if (hit[i] && !bonded) bpos[i] <= wp[i];
        if (hit[i]) age[i] <= '0;
        else if (lane_we[i] && age[i] != CW'(WIN)) age[i] <= age[i] + CW'(1);
      end
    end
  end

  p_valid_needs_bond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> bonded);
  p_align_blanks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bonded) |-> !word_valid);
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bonded) |-> $past(all_recent));
  p_enable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bond_en |=> (!bonded && !word_valid));
  p_skip_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bonded && bond_en && cc_skip) |=> !word_valid);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bonded && $past(bonded)) |-> $stable(bpos[g]));
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bonded && bond_en && cc_hold && !cc_skip) |=> $stable(rd[g]));
  end
endmodule

// File: tb/lane_bond_deskew_tb.sv
module lane_bond_deskew_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] lane_byte = '0;
  logic [3:0] lane_k = '0, lane_we = '0;
  logic bond_en = 1'b0, cc_skip = 1'b0, cc_hold = 1'b0;
  logic [31:0] word_out, word_off;
  logic word_valid, bonded, valid_off, bonded_off;

  always #2 clk = ~clk;

  lane_bond_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .lane_byte(lane_byte), .lane_k(lane_k),
    .lane_we(lane_we), .bond_en(bond_en), .cc_skip(cc_skip), .cc_hold(cc_hold),
    .word_out(word_out), .word_valid(word_valid), .bonded(bonded));

  lane_bond_deskew #(.BOND_OFFSET(3)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .lane_byte(lane_byte), .lane_k(lane_k),
    .lane_we(lane_we), .bond_en(bond_en), .cc_skip(cc_skip), .cc_hold(cc_hold),
    .word_out(word_off), .word_valid(valid_off), .bonded(bonded_off));

  int checks = 0, failures = 0;
  int scen = 0;
  int skew [4];
  int bondA = -1, bondB = -1, bondC = -1, drop_lane = -1;

  bit m_bonded, m_vld, m_areq;
  int m_cnt [4], m_bw [4], m_rd [4], m_wc [4];
  logic [31:0] m_word, m_word_off;

  function automatic logic [8:0] tx(input int n, input int l);
    if (n == bondA && l == drop_lane) return {1'b0, 8'h7C};
    if (n == bondA || n == bondB || n == bondC) return {1'b1, 8'h7C};
    return {1'b0, 8'((n * 37 + l * 91 + 5) & 255)};
  endfunction

  function automatic logic [31:0] asm_rd(input int o);
    logic [31:0] w;
    logic [8:0] t;
    for (int l = 0; l < 4; l++) begin
      t = tx(m_rd[l] - o, l);
      w[l*8 +: 8] = t[7:0];
    end
    return w;
  endfunction

  function automatic logic [31:0] alw(input int n);
    logic [31:0] w;
    logic [8:0] t;
    for (int l = 0; l < 4; l++) begin
      t = tx(n, l);
      w[l*8 +: 8] = t[7:0];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    bit ob, allr, take;
    bit hit [4];
    if (!rst_n) begin
      m_bonded = 0; m_vld = 0; m_areq = 0;
      for (int l = 0; l < 4; l++) begin
        m_cnt[l] = 8; m_bw[l] = 0; m_rd[l] = 0; m_wc[l] = 0;
      end
    end else begin
      ob = m_bonded;
      allr = 1;
      for (int l = 0; l < 4; l++) begin
        allr &= (m_cnt[l] <= 7);
        hit[l] = lane_we[l] && lane_k[l] && (lane_byte[l*8 +: 8] == 8'h7C);
      end
      take = m_areq && bond_en && !ob && allr;
      m_areq = bond_en && !ob && hit[0];
      if (!bond_en) begin
        m_bonded = 0; m_vld = 0;
      end else if (take) begin
        m_bonded = 1; m_vld = 0;
        for (int l = 0; l < 4; l++) m_rd[l] = m_bw[l];
      end else if (ob) begin
        if (cc_skip) begin
          m_vld = 0;
          for (int l = 0; l < 4; l++) m_rd[l]++;
        end else if (cc_hold) begin
          m_vld = 0;
        end else begin
          m_word = asm_rd(0);
          m_word_off = asm_rd(3);
          m_vld = 1;
          for (int l = 0; l < 4; l++) m_rd[l]++;
        end
      end else m_vld = 0;
      for (int l = 0; l < 4; l++) begin
        if (hit[l] && !ob) m_bw[l] = m_wc[l];
        if (hit[l]) m_cnt[l] = 0;
        else if (lane_we[l] && m_cnt[l] < 8) m_cnt[l]++;
        if (lane_we[l]) m_wc[l]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(bonded == m_bonded, "R3", "bonded vs model", 32'(bonded), 32'(m_bonded));
    chk(word_valid == m_vld, "R7", "valid vs model", 32'(word_valid), 32'(m_vld));
    chk(bonded_off == m_bonded, "R3", "offset bonded vs model", 32'(bonded_off), 32'(m_bonded));
    chk(valid_off == m_vld, "R7", "offset valid vs model", 32'(valid_off), 32'(m_vld));
    if (m_vld) begin
      chk(word_out == m_word, "R6", "word vs model", word_out, m_word);
      chk(word_off == m_word_off, "R6", "offset word vs model", word_off, m_word_off);
    end
  endtask

  task automatic named(input int c);
    if (c == 0) begin
      chk(bonded == 0, "R1", "bonded after reset", 32'(bonded), 0);
      chk(word_valid == 0, "R1", "valid after reset", 32'(word_valid), 0);
    end
    if (scen == 1) begin
      if (c == 24) chk(bonded == 0, "R3", "not yet bonded", 32'(bonded), 0);
      if (c == 25) begin
        chk(bonded == 1, "R3", "bonded after request", 32'(bonded), 1);
        chk(word_valid == 0, "R7", "valid low at align", 32'(word_valid), 0);
      end
      if (c == 26) begin
        chk(word_valid == 1, "R7", "first word valid", 32'(word_valid), 1);
        chk(word_out == alw(20), "R6", "first word", word_out, alw(20));
        chk(word_off == alw(17), "R6", "first offset word", word_off, alw(17));
      end
      if (c == 31) chk(word_valid == 0, "R9", "hold blanks", 32'(word_valid), 0);
      if (c == 36) chk(word_valid == 0, "R8", "skip blanks", 32'(word_valid), 0);
      if (c == 37) chk(word_out == alw(29), "R8", "word after skip", word_out, alw(29));
      if (c == 42) chk(word_out == alw(34), "R9", "skip beats hold", word_out, alw(34));
      if (c == 50) begin
        chk(word_valid == 1, "R5", "no realign while bonded", 32'(word_valid), 1);
        chk(word_out == alw(42), "R5", "stream continues", word_out, alw(42));
      end
      if (c == 51) begin
        chk(bonded == 0, "R10", "bond dropped", 32'(bonded), 0);
        chk(word_valid == 0, "R10", "valid dropped", 32'(word_valid), 0);
      end
      if (c == 66) chk(word_out == alw(60), "R10", "rebond word", word_out, alw(60));
    end
    if (scen == 2) begin
      if (c == 24) chk(bonded == 0, "R2", "data 0x7C not bonding", 32'(bonded), 0);
      if (c == 30) chk(bonded == 1, "R3", "bonded on real char", 32'(bonded), 1);
      if (c == 31) begin
        chk(word_out == alw(26), "R5", "latest position used", word_out, alw(26));
        chk(word_off == alw(23), "R5", "latest position offset", word_off, alw(23));
      end
    end
    if (scen == 3) begin
      if (c == 29) chk(bonded == 1, "R4", "skew 7 accepted", 32'(bonded), 1);
      if (c == 30) chk(word_out == alw(20), "R6", "aligned at skew 7", word_out, alw(20));
    end
    if (scen == 4 && (c == 30 || c == 34))
      chk(bonded == 0, "R4", "skew 8 refused", 32'(bonded), 0);
    if (scen == 5) begin
      if (c == 12) chk(bonded == 0, "R3", "ignored while disabled", 32'(bonded), 0);
      if (c == 22) chk(bonded == 1, "R3", "bonded after enable", 32'(bonded), 1);
      if (c == 23) chk(word_off == alw(17), "R6", "offset word", word_off, alw(17));
    end
  endtask

  task automatic run(input int n);
    rst_n = 1'b0;
    lane_we = '0; lane_k = '0; lane_byte = '0;
    cc_skip = 0; cc_hold = 0; bond_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (c > 0) compare_model();
      named(c);
      for (int l = 0; l < 4; l++) begin
        logic [8:0] t;
        if (c - skew[l] >= 0) begin
          t = tx(c - skew[l], l);
          lane_we[l] = 1'b1;
          lane_k[l] = t[8];
          lane_byte[l*8 +: 8] = t[7:0];
        end else begin
          lane_we[l] = 1'b0;
          lane_k[l] = 1'b0;
          lane_byte[l*8 +: 8] = 8'h00;
        end
      end
      cc_hold = (scen == 1) && (c == 30 || c == 31 || c == 40);
      cc_skip = (scen == 1) && (c == 35 || c == 40);
      bond_en = !((scen == 1 && (c == 50 || c == 51)) || (scen == 5 && c < 15));
    end
  endtask

  initial begin
    scen = 1; skew = '{3, 1, 0, 2}; bondA = 20; bondB = 45; bondC = 60; drop_lane = -1;
    run(80);
    scen = 2; skew = '{2, 0, 1, 0}; bondA = 20; bondB = 26; bondC = -1; drop_lane = 1;
    run(45);
    scen = 3; skew = '{7, 0, 0, 0}; bondA = 20; bondB = -1; bondC = -1; drop_lane = -1;
    run(45);
    scen = 4; skew = '{8, 0, 0, 0}; bondA = 20;
    run(40);
    scen = 5; skew = '{0, 0, 0, 0}; bondA = 10; bondB = 20;
    run(40);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=5000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule